// File: doc/BRIEF.md
# Decimator Status and Sequencing Unit

This block keeps the bookkeeping state of a decimating filter channel while the arithmetic itself lives elsewhere. It accepts input-sample strobes, each with a flag that marks the sample as invalid. It runs a per-sample down-counter that decides when an output word is due, and it raises a one-cycle output strobe at those points. It also tracks whether that output has been consumed and watches for input starvation with a saturating idle counter.

Software reaches the block through a small register port with a combinational read path and one write strobe. There are three registers:

- a 32-bit status word, which carries the live count, the busy and done handshake bits, and three sticky error flags;
- the decimation setting;
- a timeout register, which holds both the idle counter and its threshold.

Top module: `decim_status_unit`

## Requirements
- R1: After reset the status word (address 0) reads 0, and address 3 always reads 0. The decimation setting (address 1) reads 0, and the threshold field (address 2, bits 15:3) reads its reset parameter (default 8191). Status bits 31:21 and 15:12 always read 0.
- R2: An accepted sample loads the count (status bits 11:0) from the decimation setting when the count is 0, and otherwise decrements it by one. The count therefore reaches 0 once every setting+1 samples.
- R3: When an accepted sample leaves the count at 0, `outWrite` pulses for exactly one cycle, in the last busy cycle. The done bit (status bit 16) is 1 from the following cycle.
- R4: The busy bit (status bit 17) is 1 for exactly BUSY_CYCLES cycles after a sample is accepted. A sample strobe that arrives while busy is 1 has no effect on the count or the outputs.
- R5: A one-cycle `outRead` clears done. Software writes to status bits 17 and 16 have no effect.
- R6: An accepted sample whose invalid flag is 1 sets the sticky invalid-input flag (status bit 20). The sample is still counted.
- R7: The idle counter (address 2, bits 31:16) becomes 0 on an accepted sample. On every other cycle it increments by one, saturating at 65535.
- R8: The timeout flag (status bit 19) is set on the cycle after the idle counter is greater than or equal to the threshold field.
- R9: The overflow flag (status bit 18) is set when `outWrite` fires while done is still 1 and `outRead` is 0 in that cycle.
- R10: Writing 1 to status bit 20, 19 or 18 clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R11: Address 1 bits 11:0 hold the read/write decimation setting, and its upper bits read 0. Address 2 bits 15:3 hold the read/write threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Input sample strobe |
| sampleInvalid | input | 1 | Marks the presented sample as invalid |
| outRead | input | 1 | Software has read the output word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 status, 1 setting, 2 timeout) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational register read data |
| outWrite | output | 1 | One-cycle strobe: an output word is produced |

## Verification
The bench sweeps decimation settings 0 through 5 against an arithmetic model of the count. A reload off by one sample would shift both the count values and the output-strobe tally.

Samples held across the busy window must leave the count unchanged. A design that accepted them would decrement early.

Two cases exercise the same-cycle conflicts:
- An invalid sample collides with a clear-by-write. A design where the clear wins would lose the event.
- A second output arrives with done still set. A design that missed this would never raise overflow.

The timeout threshold is probed one cycle either side of the edge where the flag sets. The idle counter is driven into saturation to catch a wrap to 0.

// File: rtl/decim_status_pkg.sv
package decim_status_pkg;

  // Strobes sent from the sequencer to the datapath, all one cycle wide.
  typedef struct packed {
    logic accept;     // a sample is taken this cycle
    logic loadCount;  // reload count from the setting
    logic decCount;   // decrement count
    logic invEvent;   // accepted sample is flagged invalid
    logic ovfEvent;   // output produced while the previous one is unread
  } ctrlStrobes_t;

  localparam logic [1:0] ADDR_STATUS  = 2'd0;
  localparam logic [1:0] ADDR_DECIM   = 2'd1;
  localparam logic [1:0] ADDR_TIMEOUT = 2'd2;

  // Status word bit positions.
  localparam int BIT_INV  = 20;
  localparam int BIT_TO   = 19;
  localparam int BIT_OVF  = 18;
  localparam int BIT_BUSY = 17;
  localparam int BIT_DONE = 16;

  // Timeout register field positions.
  localparam int TO_PER_LSB = 3;
  localparam int TO_CNT_LSB = 16;

endpackage

// File: rtl/decim_status_ctrl.sv
module decim_status_ctrl
  import decim_status_pkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         sampleInvalid,
  input  logic         outRead,
  input  logic         countZero,
  input  logic         hitsZero,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done,
  output logic         outWrite
);

  localparam int BC_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BUSY_CYCLES - 1);

  logic [BC_W-1:0] busyCnt;
  logic            pendOut;
  logic            accept;
  logic            finish;

  assign accept   = sampleValid & ~busy;
  assign finish   = busy & (busyCnt == '0);
  assign outWrite = finish & pendOut;

  always_comb begin
    strobes.accept    = accept;
    strobes.loadCount = accept & countZero;
    strobes.decCount  = accept & ~countZero;
    strobes.invEvent  = accept & sampleInvalid;
    strobes.ovfEvent  = outWrite & done & ~outRead;
  end

  // Busy window sequencer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
      pendOut <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      busyCnt <= BC_LAST;
      pendOut <= hitsZero;
    end else if (finish) begin
      busy    <= 1'b0;
      pendOut <= 1'b0;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // Data-ready handshake: a new output has priority over a read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         done <= 1'b0;
    else if (outWrite) done <= 1'b1;
    else if (outRead)  done <= 1'b0;
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !busy |=> busy);

  assert_done_after_output_R3: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |=> done);

  assert_read_clears_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    outRead && !outWrite |=> !done);

endmodule

// File: rtl/decim_status_dp.sv
module decim_status_dp
  import decim_status_pkg::*;
#(
  parameter int COUNT_W      = 12,
  parameter int TO_CNT_W     = 16,
  parameter int TO_PER_W     = 13,
  parameter int PERIOD_RESET = 8191
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         busy,
  input  logic         done,
  input  logic         regWrEn,
  input  logic [1:0]   regAddr,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output logic         countZero,
  output logic         hitsZero
);

  localparam logic [TO_CNT_W-1:0] TO_MAX = '1;

  logic [COUNT_W-1:0]  decimSetting;
  logic [COUNT_W-1:0]  decimCount;
  logic [TO_CNT_W-1:0] toCnt;
  logic [TO_PER_W-1:0] toPeriod;
  logic                flagInv, flagTo, flagOvf;
  logic                statWr, decimWr, toWr;
  logic                toHit;
  logic                unusedWrBits;

  assign statWr       = regWrEn && (regAddr == ADDR_STATUS);
  assign decimWr      = regWrEn && (regAddr == ADDR_DECIM);
  assign toWr         = regWrEn && (regAddr == ADDR_TIMEOUT);
  assign unusedWrBits = ^regWrData;

  assign countZero = (decimCount == '0);
  assign hitsZero  = countZero ? (decimSetting == '0) : (decimCount == COUNT_W'(1));
  assign toHit     = (toCnt >= TO_CNT_W'(toPeriod));

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decimSetting <= '0;
      toPeriod     <= TO_PER_W'(PERIOD_RESET);
    end else begin
      if (decimWr) decimSetting <= regWrData[COUNT_W-1:0];
      if (toWr)    toPeriod     <= regWrData[TO_PER_LSB +: TO_PER_W];
    end
  end

  // Live decimation count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 decimCount <= '0;
    else if (strobes.loadCount) decimCount <= decimSetting;
    else if (strobes.decCount)  decimCount <= decimCount - COUNT_W'(1);
  end

  // Idle counter, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toCnt <= '0;
    else if (strobes.accept) toCnt <= '0;
    else if (toCnt != TO_MAX) toCnt <= toCnt + TO_CNT_W'(1);
  end

  // Sticky flags: a set event beats a same-cycle write-one clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagInv <= 1'b0;
      flagTo  <= 1'b0;
      flagOvf <= 1'b0;
    end else begin
      flagInv <= strobes.invEvent | (flagInv & ~(statWr & regWrData[BIT_INV]));
      flagTo  <= toHit            | (flagTo  & ~(statWr & regWrData[BIT_TO]));
      flagOvf <= strobes.ovfEvent | (flagOvf & ~(statWr & regWrData[BIT_OVF]));
    end
  end

  // Read path.
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_STATUS: begin
        regRdData[COUNT_W-1:0] = decimCount;
        regRdData[BIT_DONE]    = done;
        regRdData[BIT_BUSY]    = busy;
        regRdData[BIT_OVF]     = flagOvf;
        regRdData[BIT_TO]      = flagTo;
        regRdData[BIT_INV]     = flagInv;
      end
      ADDR_DECIM:   regRdData[COUNT_W-1:0] = decimSetting;
      ADDR_TIMEOUT: begin
        regRdData[TO_PER_LSB +: TO_PER_W] = toPeriod;
        regRdData[TO_CNT_LSB +: TO_CNT_W] = toCnt;
      end
      default: regRdData = '0;
    endcase
  end

  assert_count_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decCount |=> decimCount == $past(decimCount) - COUNT_W'(1));

  assert_count_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> decimCount == $past(decimSetting));

  assert_idle_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> toCnt == '0);

  assert_timeout_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    toHit |=> flagTo);

  assert_overflow_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ovfEvent |=> flagOvf);

  assert_sticky_inv_R10: assert property (@(posedge clk) disable iff (!rstN)
    flagInv && !(statWr && regWrData[BIT_INV]) |=> flagInv);

endmodule

// File: rtl/decim_status_unit.sv
module decim_status_unit
  import decim_status_pkg::*;
#(
  parameter int COUNT_W      = 12,
  parameter int TO_CNT_W     = 16,
  parameter int TO_PER_W     = 13,
  parameter int PERIOD_RESET = 8191,
  parameter int BUSY_CYCLES  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        sampleInvalid,
  input  logic        outRead,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        outWrite
);

  ctrlStrobes_t strobes;
  logic         busy, done, countZero, hitsZero;

  decim_status_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sampleInvalid(sampleInvalid),
    .outRead      (outRead),
    .countZero    (countZero),
    .hitsZero     (hitsZero),
    .strobes      (strobes),
    .busy         (busy),
    .done         (done),
    .outWrite     (outWrite)
  );

  decim_status_dp #(
    .COUNT_W     (COUNT_W),
    .TO_CNT_W    (TO_CNT_W),
    .TO_PER_W    (TO_PER_W),
    .PERIOD_RESET(PERIOD_RESET)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .countZero(countZero),
    .hitsZero (hitsZero)
  );

endmodule

// File: tb/decim_status_unit_tb_top.sv
module decim_status_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0, sampleInvalid = 1'b0, outRead = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        outWrite;

  int checks = 0, errors = 0, outCnt = 0;
  int curD = 0, expCount = 0, expOut = 0;
  bit expDone = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  decim_status_unit #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleInvalid(sampleInvalid),
    .outRead(outRead), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .outWrite(outWrite)
  );

  always @(negedge clk) if (rstN && outWrite) outCnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  function automatic void modelSample();
    if (expCount == 0) expCount = curD; else expCount--;
    if (expCount == 0) begin
      expOut++;
      expDone = 1;
    end
  endfunction

  task automatic pulseRead();
    @(negedge clk); outRead = 1'b1;
    @(negedge clk); outRead = 1'b0;
    expDone = 0;
  endtask

  // One sample, then wait out the busy window and check the count and handshake.
  task automatic processSample(input bit inv, input bit clearDone);
    @(negedge clk); sampleValid = 1'b1; sampleInvalid = inv;
    @(negedge clk); sampleValid = 1'b0; sampleInvalid = 1'b0;
    modelSample();
    repeat (BUSY) @(negedge clk);
    readReg(2'd0, rd);
    check("R2 count", {20'd0, rd[11:0]}, expCount);
    check("R3 done", {31'd0, rd[16]}, {31'd0, expDone});
    check("R3 outWrite tally", outCnt, expOut);
    if (clearDone && expDone) begin
      pulseRead();
      readReg(2'd0, rd);
      check("R5 done cleared by read", {31'd0, rd[16]}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    readReg(2'd0, rd); check("R1 status reset", rd, 32'd0);
    readReg(2'd1, rd); check("R1 setting reset", rd, 32'd0);
    readReg(2'd2, rd); check("R1 threshold reset", {16'd0, rd[15:0]}, 32'h0000_FFF8);
    readReg(2'd3, rd); check("R1 addr3 zero", rd, 32'd0);

    // R11 setting width
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, rd); check("R11 setting bits", rd, 32'h0000_0FFF);

    // R4 busy window length
    writeReg(2'd1, 32'd2); curD = 2;
    @(negedge clk); sampleValid = 1'b1;
    @(negedge clk); sampleValid = 1'b0; modelSample();
    readReg(2'd0, rd); check("R4 busy first cycle", {31'd0, rd[17]}, 32'd1);
    repeat (BUSY - 1) @(negedge clk);
    readReg(2'd0, rd); check("R4 busy last cycle", {31'd0, rd[17]}, 32'd1);
    @(negedge clk);
    readReg(2'd0, rd); check("R4 busy dropped", {31'd0, rd[17]}, 32'd0);
    check("R2 first load", {20'd0, rd[11:0]}, expCount);
    readReg(2'd2, rd); check("R7 idle count after sample", {16'd0, rd[31:16]}, BUSY);

    // R2/R3 sweep over settings
    for (int d = 0; d <= 5; d++) begin
      writeReg(2'd1, d); curD = d;
      for (int s = 0; s < 2 * (d + 1) + 1; s++) processSample(0, 1);
    end

    // R4 strobe held during busy is ignored
    writeReg(2'd1, 32'd5); curD = 5;
    @(negedge clk); sampleValid = 1'b1;
    @(negedge clk); modelSample();
    @(negedge clk); sampleValid = 1'b0;
    repeat (BUSY - 1) @(negedge clk);
    readReg(2'd0, rd); check("R4 ignored while busy", {20'd0, rd[11:0]}, expCount);
    check("R4 no extra output", outCnt, expOut);

    // R6 invalid sample, R10 clear by write-one
    processSample(1, 1);
    readReg(2'd0, rd); check("R6 invalid flag set", {31'd0, rd[20]}, 32'd1);
    writeReg(2'd0, 32'd0);
    readReg(2'd0, rd); check("R10 write zero keeps flag", {31'd0, rd[20]}, 32'd1);
    writeReg(2'd0, 32'h0010_0000);
    readReg(2'd0, rd); check("R10 write one clears", {31'd0, rd[20]}, 32'd0);

    // R10 set wins over clear
    @(negedge clk);
    sampleValid = 1'b1; sampleInvalid = 1'b1;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h0010_0000;
    @(negedge clk);
    sampleValid = 1'b0; sampleInvalid = 1'b0; regWrEn = 1'b0; regWrData = '0;
    modelSample();
    repeat (BUSY) @(negedge clk);
    readReg(2'd0, rd); check("R10 set beats clear", {31'd0, rd[20]}, 32'd1);
    if (expDone) pulseRead();

    // R9 overflow, R5 write to handshake bits
    writeReg(2'd1, 32'd0); curD = 0;
    while (expCount != 0) processSample(0, 1);
    processSample(0, 0);
    readReg(2'd0, rd); check("R9 no overflow yet", {31'd0, rd[18]}, 32'd0);
    writeReg(2'd0, 32'h0003_0000);
    readReg(2'd0, rd); check("R5 write ignored on done", {31'd0, rd[16]}, 32'd1);
    processSample(0, 0);
    readReg(2'd0, rd); check("R9 overflow set", {31'd0, rd[18]}, 32'd1);
    pulseRead();
    writeReg(2'd0, 32'h0004_0000);
    readReg(2'd0, rd); check("R10 overflow cleared", {31'd0, rd[18]}, 32'd0);

    // R8 threshold edge
    writeReg(2'd2, 32'd20 << 3);
    readReg(2'd2, rd); check("R11 threshold field", {16'd0, rd[15:0]}, 32'd160);
    processSample(0, 0);
    repeat (17) @(negedge clk);
    readReg(2'd2, rd); check("R7 idle count 20", {16'd0, rd[31:16]}, 32'd20);
    readReg(2'd0, rd); check("R8 not yet", {31'd0, rd[19]}, 32'd0);
    @(negedge clk);
    readReg(2'd0, rd); check("R8 timeout set", {31'd0, rd[19]}, 32'd1);
    if (expDone) pulseRead();

    // R7 saturation
    repeat (65540) @(negedge clk);
    readReg(2'd2, rd); check("R7 saturates", {16'd0, rd[31:16]}, 32'h0000_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule